// File: doc/BRIEF.md
# Float Reciprocal by Newton Iteration

This unit forms an approximate reciprocal of a number held in a compact 18-bit floating format. The format is one sign bit in bit 17, an 8-bit exponent in bits 16:9 with offset 128, and a 9-bit fraction in bits 8:0. A value is (-1)^sign · (fraction/512) · 2^(exponent-128). The fraction's top bit (bit 8, worth 0.5) is always set for a nonzero value. The format has no rounding, no special values and no subnormals.

A one-cycle `start` pulse loads the operand. The unit then sets the sign to positive and the exponent to 128, which reduces the operand to r in [0.5, 1). From r it builds a linear first guess, 2.9140625 − 2r. Two Newton steps of the form x·(2 − r·x) refine that guess. The steps run on one shared float multiplier and one shared float adder, and a small state machine orders them. The result fraction is the fraction of the last iterate. The result exponent comes straight from the operand exponent, and the operand sign is put back on the result. `done` pulses for one cycle when `y_out` takes the new result. A zero operand and exponents outside the stated range are not handled.

Top module: `fp_recip`

## Requirements
- R1: While `rst_n` is low at a rising edge, `done` goes to 0 and `y_out` goes to 0.
- R2: When `start` is high at a rising edge and the unit is idle, the operand on `x_in` is captured. `done` goes high at the seventh rising edge after that one, and it is high for exactly one cycle.
- R3: `start` has no effect from the capturing edge up to and including the edge that raises `done`. The result still belongs to the operand that was captured first.
- R4: The reduced operand is r = {0, 8'h80, m}, where m = `x_in`[8:0]. The first guess is 18'h10575 (2.9140625) plus {1, 8'h81, m}, computed with the float addition of R7.
- R5: Each of the two refinement steps computes t = r⊗x, then t' = 18'h10500 (2.0) ⊕ (t with its sign flipped), then x ← x⊗t'.
- R6: Float multiply a⊗b: the result is all zeros if either fraction bit 8 is clear, or if ea+eb < 129. Otherwise let P be the 18-bit product of the fractions. If P[17]=1, the fraction is P[17:9] and the exponent is ea+eb−128. If P[17]=0, the fraction is P[16:8] and the exponent is ea+eb−129. The sign is the XOR of the two signs.
- R7: Float add a⊕b: the result is all zeros if both fraction bit 8s are clear. The larger magnitude is chosen by comparing {exponent, fraction}, with a taken on a tie. If the exponent gap is above 8, the result is the larger operand. Otherwise the smaller fraction is shifted right by the gap. With equal signs the fractions are added, and a carry shifts the result right once and raises the exponent by one. With unequal signs the fractions are subtracted: a zero difference gives all zeros, and any other difference is shifted left until bit 8 is set, with the exponent lowered by one per shift. A nonzero result takes the sign of the larger operand.
- R8: The result is `y_out` = {s, e_out, fraction of the final iterate}. e_out is (9'h102 − e) when m = 9'h100, and (9'h101 − e) otherwise, kept to 8 bits. This applies to input exponents e from 3 to 255.
- R9: `y_out`[17] equals the sign bit of the captured operand.
- R10: For operands whose final iterate has exponent 8'h81, and for exact powers of two, x·`y_out` is within 10·2^-9 of 1.0.
- R11: `y_out` holds its value in every cycle except the cycle that follows a `done` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a reciprocal; honoured only while idle |
| x_in | input | 18 | Operand {sign, exponent, fraction} |
| done | output | 1 | One-cycle pulse when `y_out` is updated |
| y_out | output | 18 | Reciprocal of the last captured operand |

## Verification
The embedded properties are checked on every cycle. They cover the one-cycle `done` pulse and the captured operand staying frozen while the unit is busy. They also check that the multiplier and adder always return either zero or a normalized fraction, that the first guess lands between 0.5 and 2, and that every 2 − r·x term is positive and normalized. Only the bench's scenarios can show the exact result bits. Those come from a behavioural model of the float operations, replayed every clock against `done` and `y_out`. The same holds for the seven-cycle latency, the exponent correction for exact powers of two, the rejection of a mid-run `start` carrying a different operand, and the closeness of x·(1/x) to one.

// File: rtl/fprcp_pkg.sv
// Package: format widths, the float record type and the sequencer states
// shared by the reciprocal unit and its arithmetic blocks.
// Assumes a sign / offset-exponent / fraction layout with the fraction MSB
// carrying 0.5 for every nonzero value.
package fprcp_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 9;
    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int BIAS  = 1 << (EXP_W - 1);

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_PROD,
        ST_DIFF,
        ST_UPD
    } rcp_state_e;
endpackage

// File: rtl/fp18_mul.sv
// Module: combinational float multiply.
// Truncates the fraction product to MAN_W bits, renormalizing by at most one
// place. Assumes nonzero inputs are normalized; underflow flushes to zero.
module fp18_mul
    import fprcp_pkg::*;
(
    input  fp_t a,
    input  fp_t b,
    output fp_t y
);
    localparam int PROD_W = 2 * MAN_W;

    logic [EXP_W:0] esum;
    logic [MAN_W:0] top_bits;
    logic           valid;

    // Exponent sum, top product bits and the zero/underflow test
    always_comb begin
        esum     = {1'b0, a.exp} + {1'b0, b.exp};
        top_bits = (MAN_W+1)'(({{MAN_W{1'b0}}, a.man} * {{MAN_W{1'b0}}, b.man}) >> (MAN_W - 1));
        valid    = a.man[MAN_W-1] && b.man[MAN_W-1] && (esum >= (EXP_W+1)'(BIAS + 1));
    end

    // Pick the normalizing shift and assemble the result
    always_comb begin
        y = '0;
        if (valid) begin
            y.sgn = a.sgn ^ b.sgn;
            if (top_bits[MAN_W]) begin
                y.man = top_bits[MAN_W:1];
                y.exp = EXP_W'(esum - (EXP_W+1)'(BIAS));
            end else begin
                y.man = top_bits[MAN_W-1:0];
                y.exp = EXP_W'(esum - (EXP_W+1)'(BIAS + 1));
            end
        end
    end

    // Unused in PROD_W sizing guard: keep the width tie explicit
    initial begin
        if (PROD_W != 2 * MAN_W) $display("fp18_mul: width mismatch");
    end
endmodule

// File: rtl/fp18_add.sv
// Module: combinational float add/subtract.
// Orders operands by magnitude, aligns the smaller with a right shift
// (truncating), adds or subtracts fractions, then renormalizes.
// Assumes normalized or all-zero inputs; no exponent overflow checks.
module fp18_add
    import fprcp_pkg::*;
(
    input  fp_t a,
    input  fp_t b,
    output fp_t y
);
    localparam int LZ_W   = $clog2(MAN_W + 1);
    localparam int SH_MAX = MAN_W - 1;

    fp_t              big;
    fp_t              sml;
    logic [EXP_W-1:0] ediff;
    logic [MAN_W-1:0] sm_sh;
    logic [MAN_W:0]   sum;
    logic [MAN_W-1:0] dif;
    logic [LZ_W-1:0]  lz;
    logic             found;

    // Order by magnitude, a wins a tie
    always_comb begin
        if ({a.exp, a.man} >= {b.exp, b.man}) begin
            big = a;
            sml = b;
        end else begin
            big = b;
            sml = a;
        end
        ediff = big.exp - sml.exp;
    end

    // Align the smaller fraction and form both the sum and the difference
    always_comb begin
        sm_sh = sml.man >> ediff;
        sum   = {1'b0, big.man} + {1'b0, sm_sh};
        dif   = big.man - sm_sh;
    end

    // Count leading zeros of the difference
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (dif[i]) found = 1'b1;
                else        lz = lz + LZ_W'(1);
            end
        end
    end

    // Select the result path
    always_comb begin
        y = '0;
        if (!a.man[MAN_W-1] && !b.man[MAN_W-1]) begin
            y = '0;
        end else if (ediff > EXP_W'(SH_MAX)) begin
            y = big;
        end else if (big.sgn == sml.sgn) begin
            y.sgn = big.sgn;
            if (sum[MAN_W]) begin
                y.exp = big.exp + EXP_W'(1);
                y.man = sum[MAN_W:1];
            end else begin
                y.exp = big.exp;
                y.man = sum[MAN_W-1:0];
            end
        end else if (dif != '0) begin
            y.sgn = big.sgn;
            y.exp = big.exp - EXP_W'(lz);
            y.man = dif << lz;
        end
    end
endmodule

// File: rtl/fprcp_ctrl.sv
// Module: sequencer for the reciprocal.
// Steps seed -> (product -> difference -> update) x ITERS, then back to idle.
// A start request is only seen in ST_IDLE. `last` flags the final update.
module fprcp_ctrl
    import fprcp_pkg::*;
#(
    parameter int ITERS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output rcp_state_e st,
    output logic       last
);
    localparam int IT_W = (ITERS > 1) ? $clog2(ITERS) : 1;

    logic [IT_W-1:0] it_q;

    assign last = (it_q == IT_W'(ITERS - 1));

    // State and iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            it_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st   <= ST_SEED;
                    it_q <= '0;
                end
                ST_SEED: st <= ST_PROD;
                ST_PROD: st <= ST_DIFF;
                ST_DIFF: st <= ST_UPD;
                ST_UPD: begin
                    if (last) begin
                        st <= ST_IDLE;
                    end else begin
                        st   <= ST_PROD;
                        it_q <= it_q + IT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fp_recip.sv
// Module: top of the float reciprocal.
// Captures the operand on an idle start, runs the seed and ITERS Newton
// steps on one shared multiplier and adder, and then writes the result and
// pulses done. Assumes a normalized nonzero operand with exponent 3..255.
module fp_recip
    import fprcp_pkg::*;
#(
    parameter int              ITERS  = 2,
    parameter logic [FP_W-1:0] SEED_C = 18'h10575,
    parameter logic [FP_W-1:0] TWO_C  = 18'h10500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FP_W-1:0] x_in,
    output logic            done,
    output logic [FP_W-1:0] y_out
);
    localparam int               RCP_K    = 2 * BIAS + 1;
    localparam logic [MAN_W-1:0] MAN_HALF = MAN_W'(1) << (MAN_W - 1);
    localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS + 1);

    rcp_state_e       st;
    logic             last;
    logic             s_q;
    logic [EXP_W-1:0] e1_q;
    logic [MAN_W-1:0] m1_q;
    fp_t              x_q;
    fp_t              t_q;
    fp_t              r_v;
    fp_t              neg_two_r;
    fp_t              mul_a;
    fp_t              mul_b;
    fp_t              mul_y;
    fp_t              add_a;
    fp_t              add_b;
    fp_t              add_y;
    logic [EXP_W-1:0] eout;
    logic             done_q;
    logic [FP_W-1:0]  y_q;

    fprcp_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .st    (st),
        .last  (last)
    );

    // Reduced operand r and the negated 2r used by the seed
    always_comb begin
        r_v       = '{sgn: 1'b0, exp: EXP_HALF, man: m1_q};
        neg_two_r = '{sgn: 1'b1, exp: EXP_ONE,  man: m1_q};
    end

    // Operand steering for the shared multiplier and adder
    always_comb begin
        mul_a = (st == ST_PROD) ? r_v : x_q;
        mul_b = (st == ST_PROD) ? x_q : t_q;
        add_a = (st == ST_SEED) ? fp_t'(SEED_C) : fp_t'(TWO_C);
        add_b = (st == ST_SEED) ? neg_two_r : '{sgn: ~t_q.sgn, exp: t_q.exp, man: t_q.man};
    end

    fp18_mul u_mul (.a(mul_a), .b(mul_b), .y(mul_y));
    fp18_add u_add (.a(add_a), .b(add_b), .y(add_y));

    // Result exponent from the input exponent, with the power-of-two correction
    always_comb begin
        eout = (m1_q == MAN_HALF) ? (EXP_W'(RCP_K + 1) - e1_q) : (EXP_W'(RCP_K) - e1_q);
    end

    // Operand capture, idle only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q  <= 1'b0;
            e1_q <= '0;
            m1_q <= '0;
        end else if (st == ST_IDLE && start) begin
            s_q  <= x_in[FP_W-1];
            e1_q <= x_in[FP_W-2 -: EXP_W];
            m1_q <= x_in[MAN_W-1:0];
        end
    end

    // Iterate and scratch registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            t_q <= '0;
        end else begin
            case (st)
                ST_SEED: x_q <= add_y;
                ST_PROD: t_q <= mul_y;
                ST_DIFF: t_q <= add_y;
                ST_UPD:  x_q <= mul_y;
                default: ;
            endcase
        end
    end

    // Result register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st == ST_UPD && last) begin
                y_q    <= {s_q, eout, mul_y.man};
                done_q <= 1'b1;
            end
        end
    end

    assign done  = done_q;
    assign y_out = y_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R2

    AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(m1_q) && $stable(e1_q) && $stable(s_q))); // R3

    AST_SEED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEED && m1_q[MAN_W-1]) |->
            (add_y.man[MAN_W-1] && !add_y.sgn && (add_y.exp == EXP_HALF || add_y.exp == EXP_ONE))); // R4

    AST_DIFF_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DIFF && m1_q[MAN_W-1]) |-> (add_y.man[MAN_W-1] && !add_y.sgn)); // R5

    AST_MUL_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_a.man[MAN_W-1] && mul_b.man[MAN_W-1] &&
         (({1'b0, mul_a.exp} + {1'b0, mul_b.exp}) >= (EXP_W+1)'(BIAS + 1))) |-> mul_y.man[MAN_W-1]); // R6

    AST_MUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mul_a.man[MAN_W-1] || !mul_b.man[MAN_W-1]) |-> (mul_y == '0)); // R6

    AST_ADD_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && (|add_y.man)) |-> add_y.man[MAN_W-1]); // R7
endmodule

// File: tb/fp_recip_tb.sv
module fp_recip_tb;
    localparam int CLK_P = 10;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] x_in  = '0;
    logic        done;
    logic [17:0] y_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fp_recip u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .x_in  (x_in),
        .done  (done),
        .y_out (y_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural float multiply (R6)
    function automatic logic [17:0] m_mul(input logic [17:0] a, input logic [17:0] b);
        int ea, eb, p;
        ea = a[16:9];
        eb = b[16:9];
        if (!a[8] || !b[8] || (ea + eb) < 129) return 18'h0;
        p = int'(a[8:0]) * int'(b[8:0]);
        if (p >= 131072) return {a[17] ^ b[17], 8'(ea + eb - 128), 9'(p / 512)};
        return {a[17] ^ b[17], 8'(ea + eb - 129), 9'(p / 256)};
    endfunction

    // Behavioural float add (R7)
    function automatic logic [17:0] m_add(input logic [17:0] a, input logic [17:0] b);
        logic [17:0] bg, sl;
        int eb, d, mb, ms, s;
        if (!a[8] && !b[8]) return 18'h0;
        if (a[16:0] >= b[16:0]) begin bg = a; sl = b; end
        else begin bg = b; sl = a; end
        eb = bg[16:9];
        d  = eb - int'(sl[16:9]);
        if (d > 8) return bg;
        mb = bg[8:0];
        ms = int'(sl[8:0]) >> d;
        if (bg[17] == sl[17]) begin
            s = mb + ms;
            if (s >= 512) return {bg[17], 8'(eb + 1), 9'(s / 2)};
            return {bg[17], 8'(eb), 9'(s)};
        end
        s = mb - ms;
        if (s == 0) return 18'h0;
        while (s < 256) begin
            s  = s * 2;
            eb = eb - 1;
        end
        return {bg[17], 8'(eb), 9'(s)};
    endfunction

    // Seed and two refinements (R4, R5)
    function automatic logic [17:0] m_x2(input logic [8:0] m);
        logic [17:0] r, xx, t;
        r  = {1'b0, 8'h80, m};
        xx = m_add(18'h10575, {1'b1, 8'h81, m});
        for (int i = 0; i < 2; i++) begin
            t  = m_mul(r, xx);
            t  = m_add(18'h10500, {~t[17], t[16:0]});
            xx = m_mul(xx, t);
        end
        return xx;
    endfunction

    // Full result (R8, R9)
    function automatic logic [17:0] m_rcp(input logic [17:0] x);
        logic [17:0] xx;
        logic [8:0]  eo;
        xx = m_x2(x[8:0]);
        eo = (x[8:0] == 9'h100) ? (9'h102 - {1'b0, x[16:9]}) : (9'h101 - {1'b0, x[16:9]});
        return {x[17], eo[7:0], xx[8:0]};
    endfunction

    // Cycle reference: busy window, latency and held output
    bit          m_busy = 1'b0;
    int          m_cnt  = 0;
    logic [17:0] m_pend = '0;
    bit          exp_done = 1'b0;
    logic [17:0] exp_y = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy   = 1'b0;
            m_cnt    = 0;
            exp_done = 1'b0;
            exp_y    = '0;
        end else begin
            exp_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    exp_done = 1'b1;
                    exp_y    = m_pend;
                    m_busy   = 1'b0;
                end
            end else if (start) begin
                m_pend = m_rcp(x_in);
                m_busy = 1'b1;
                m_cnt  = 7;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(done === exp_done, "R2 done timing", 32'(done), 32'(exp_done));
            chk(y_out === exp_y, "R11 y_out vs reference", 32'(y_out), 32'(exp_y));
        end
    end

    task automatic run(input logic [17:0] xa, input bit intrude, input logic [17:0] xb, input string tag);
        int          w;
        int          ex;
        real         p;
        logic [17:0] ey, x2;
        @(negedge clk);
        start = 1'b1;
        x_in  = xa;
        w     = 0;
        do begin
            @(negedge clk);
            w++;
            if (w == 1) start = 1'b0;
            if (intrude && w == 3) begin start = 1'b1; x_in = xb; end
            if (intrude && w == 4) start = 1'b0;
        end while (!done && w < 40);
        ey = m_rcp(xa);
        chk(w == 8, "R2 latency in cycles", 32'(w), 32'd8);
        chk(y_out == ey, tag, 32'(y_out), 32'(ey));
        chk(y_out[17] == xa[17], "R9 sign", 32'(y_out[17]), 32'(xa[17]));
        x2 = m_x2(xa[8:0]);
        if (x2[16:9] == 8'h81 || xa[8:0] == 9'h100) begin
            ex = int'(xa[16:9]) + int'(y_out[16:9]) - 256;
            p  = (real'(int'(xa[8:0]) * int'(y_out[8:0])) / 262144.0) * (2.0 ** ex);
            n_chk++;
            if (p < 1.0 - 10.0/512.0 || p > 1.0 + 10.0/512.0) begin
                n_fail++;
                $display("FAIL R10 x*y actual=%f expected=1.0 (x=%h y=%h)", p, xa, y_out);
            end
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
        chk(y_out == 18'h0, "R1 y_out in reset", 32'(y_out), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run({1'b0, 8'h80, 9'h100}, 1'b0, '0, "R8 reciprocal of 0.5");
        chk(y_out == 18'h10500, "R8 1/0.5 is 2.0", 32'(y_out), 32'h10500);
        run({1'b0, 8'h83, 9'h100}, 1'b0, '0, "R8 reciprocal of 4.0");
        chk(y_out == 18'h0FF00, "R8 1/4 is 0.25", 32'(y_out), 32'h0FF00);
        run({1'b1, 8'h81, 9'h100}, 1'b0, '0, "R9 reciprocal of -1.0");
        chk(y_out == 18'h30300, "R9 1/-1 is -1", 32'(y_out), 32'h30300);
        run({1'b0, 8'h80, 9'h1FF}, 1'b0, '0, "R5 largest fraction");
        chk(y_out == 18'h10302, "R5 R6 R7 hand-worked x2", 32'(y_out), 32'h10302);
        run({1'b0, 8'h90, 9'h101}, 1'b0, '0, "R8 iterate reaching 2.0");
        chk(y_out == 18'h0E300, "R8 fraction taken from x2", 32'(y_out), 32'h0E300);
        run({1'b0, 8'h85, 9'h155}, 1'b1, 18'h3FFFF, "R3 start ignored while busy");
        run({1'b0, 8'h03, 9'h1A3}, 1'b0, '0, "R8 low exponent edge");
        run({1'b1, 8'hFF, 9'h100}, 1'b0, '0, "R8 high exponent power of two");
        run({1'b0, 8'hFF, 9'h1C0}, 1'b0, '0, "R8 high exponent edge");

        for (int k = 0; k < 150; k++) begin
            logic [17:0] xr;
            xr[17]   = 1'($urandom);
            xr[16:9] = 8'(3 + ($urandom % 253));
            xr[8:0]  = 9'(256 + ($urandom % 256));
            if (k % 10 == 0) xr[8:0] = 9'h100;
            run(xr, (k % 7) == 3, 18'h2AAAA, "R4 R5 R6 R7 R8 random operand");
        end

        repeat (6) @(negedge clk);
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule